// File: doc/BRIEF.md
# Host-Driven Configuration Loader

This block sits between a host processor's register bus and a device's configuration logic. The host sees three registers: control, status and data. It clears and re-sets a program bit to restart configuration. It waits for the init flag, then writes configuration bytes one at a time. Each byte goes through a hold register into a shift register. The shift register sends the byte out most significant bit first. The output is either a local serial port, paced at one bit every `LOC_DIV` clocks, or a chain output toward downstream devices, at one bit per clock.

A control bit sets how data writes are acknowledged. In held mode, the acknowledge for a data write is delayed until the byte has moved into the shift register, so the bus itself paces the host. In early mode, every access is acknowledged on the next cycle. The host must then pace itself by reading the ready bit or by enabling the ready-rise interrupt. In early mode, a data write made while the block is not ready is discarded and a sticky error flag is raised.

Bus access: the host raises `req` with `we`, `addr` and `wdata` and holds all of them until it sees `ack`. It drops `req` in the cycle after `ack` and leaves at least one idle cycle before the next request. `ack` is a single-cycle pulse. Read data is valid in `rdata` while `ack` is high.

Top module: `cfg_host_ctrl`

## Requirements
- R1: After reset, both registers read 0x00. The control register is at address 0 and has bit0 program, bit1 hold-bus, bit2 chain mode and bit3 interrupt enable. It reads back as written.
- R2: Status bit1 (init) goes to 1 `INIT_DLY` clocks after the program bit is written to 1. While program is 0, init is 0, the buffered bytes are discarded and serial output stops.
- R3: Status bit0 (ready) is 1 only when program and init are set and the hold register is empty. In chain mode, ready also stays 0 until the last bit of the current byte has been shifted out.
- R4: A byte written to address 2 is sent MSB first. In local mode it appears on `loc_dat` with one `loc_vld` strobe every `LOC_DIV` clocks. In chain mode it appears on `chain_dat` with `chain_vld` on consecutive clocks. The lane that is not selected stays silent.
- R5: With hold-bus 0, every access, data writes included, is acknowledged one cycle after it is accepted.
- R6: With hold-bus 1 and init set, a data write is not acknowledged until its byte has entered the shift register. A second write that follows a byte still being shifted therefore waits for that shift to finish.
- R7: A data write that cannot be taken is discarded and sets sticky status bit3. This covers an early-mode write while ready is 0, and any write while program or init is 0. Writing 1 to status bit3 clears the flag.
- R8: When interrupt enable is set, a rising edge of ready sets `irq` and status bit7. Writing 1 to status bit7 clears both.
- R9: `ack` is a one-cycle pulse that answers a request held in the previous cycle. Reads of address 2 or 3 return 0.
- R10: Status bit2 follows the `cfg_done` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Bus request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with ack |
| ack | output | 1 | One-cycle bus acknowledge |
| cfg_done | input | 1 | Configuration-complete flag from the device |
| irq | output | 1 | Ready-rise interrupt |
| loc_dat | output | 1 | Local serial data |
| loc_vld | output | 1 | Local bit strobe |
| chain_dat | output | 1 | Chain serial data |
| chain_vld | output | 1 | Chain bit strobe |

## Verification
Some properties are checked on every cycle. `ack` is a single pulse that follows a held request. Ready never rises without program and init. Ready stays low while a chain bit is being sent. A low program bit removes init and stops both lanes on the next cycle. A ready rise with the interrupt enabled raises `irq`.

Other behaviour only the directed scenarios can show. These cover the bit order of the serial stream and the spacing of the local strobes. They also cover how long a held-mode acknowledge waits compared with an early one, which bytes survive a burst of writes, and the set and clear behaviour of the sticky error and interrupt flags.

// File: rtl/cfg_host_ctrl.sv
module cfg_host_ctrl #(
  parameter int INIT_DLY = 16,
  parameter int LOC_DIV  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       ack,
  input  logic       cfg_done,
  output logic       irq,
  output logic       loc_dat,
  output logic       loc_vld,
  output logic       chain_dat,
  output logic       chain_vld
);
  localparam int IW = $clog2(INIT_DLY + 1);
  localparam int DW = $clog2(LOC_DIV + 1);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef enum logic [1:0] {P_IDLE, P_WAIT, P_LOAD} pend_t;

  logic          prog, hold_bus, daisy, ie;
  logic          init;
  logic [IW-1:0] icnt;
  logic [7:0]    hold_q, sh_q;
  logic          hold_full;
  logic [3:0]    sh_cnt;
  logic [DW-1:0] div;
  logic          err, irq_q, rdy_q, ack_q;
  logic [7:0]    rdata_q;
  pend_t         pst;

  logic busy_sh, rdy, tick, shift_ld, go, dwr, can_wait, drop, take_now, hold_ld, ack_nxt;
  logic ctrl_wr, stat_wr;
  logic [7:0] status;

  assign busy_sh  = sh_cnt != 4'd0;
  assign rdy      = prog & init & ~hold_full & ~(daisy & busy_sh);
  assign tick     = busy_sh & (daisy | (div == DW'(LOC_DIV - 1)));
  assign shift_ld = ~busy_sh & hold_full;

  assign go       = req & ~ack_q & (pst == P_IDLE);
  assign ctrl_wr  = go & we & (addr == A_CTRL);
  assign stat_wr  = go & we & (addr == A_STAT);
  assign dwr      = go & we & (addr == A_DATA);
  assign can_wait = hold_bus & prog & init;
  assign take_now = dwr & rdy;
  assign drop     = dwr & ~rdy & ~can_wait;
  assign hold_ld  = take_now | ((pst == P_WAIT) & rdy);
  assign ack_nxt  = (go & ~(dwr & hold_bus & ~drop)) | ((pst == P_LOAD) & shift_ld);

  assign status    = {irq_q, 3'b000, err, cfg_done, init, rdy};
  assign rdata     = rdata_q;
  assign ack       = ack_q;
  assign irq       = irq_q;
  assign loc_vld   = tick & ~daisy;
  assign chain_vld = tick & daisy;
  assign loc_dat   = sh_q[7] & ~daisy;
  assign chain_dat = sh_q[7] & daisy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ie, daisy, hold_bus, prog} <= 4'b0000;
      init      <= 1'b0;
      icnt      <= '0;
      hold_q    <= 8'h00;
      hold_full <= 1'b0;
      sh_q      <= 8'h00;
      sh_cnt    <= 4'd0;
      div       <= '0;
      err       <= 1'b0;
      irq_q     <= 1'b0;
      rdy_q     <= 1'b0;
      ack_q     <= 1'b0;
      rdata_q   <= 8'h00;
      pst       <= P_IDLE;
    end else begin
      ack_q <= ack_nxt;
      rdy_q <= rdy;

      if (go & ~we)
        rdata_q <= (addr == A_CTRL) ? {4'b0000, ie, daisy, hold_bus, prog} :
                   (addr == A_STAT) ? status : 8'h00;

      if (ctrl_wr) {ie, daisy, hold_bus, prog} <= wdata[3:0];

      if (!prog) begin
        init <= 1'b0;
        icnt <= '0;
      end else if (!init) begin
        if (icnt == IW'(INIT_DLY - 1)) init <= 1'b1;
        else icnt <= icnt + 1'b1;
      end

      if (!prog) begin
        hold_full <= 1'b0;
        sh_cnt    <= 4'd0;
        div       <= '0;
      end else begin
        if (shift_ld) begin
          sh_q      <= hold_q;
          sh_cnt    <= 4'd8;
          hold_full <= 1'b0;
          div       <= '0;
        end else if (tick) begin
          sh_q   <= {sh_q[6:0], 1'b0};
          sh_cnt <= sh_cnt - 4'd1;
          div    <= '0;
        end else if (busy_sh) begin
          div <= div + 1'b1;
        end
        if (hold_ld) begin
          hold_q    <= wdata;
          hold_full <= 1'b1;
        end
      end

      case (pst)
        P_IDLE: if (dwr & hold_bus & ~drop) pst <= take_now ? P_LOAD : P_WAIT;
        P_WAIT: if (rdy) pst <= P_LOAD;
        P_LOAD: if (shift_ld) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase

      if (drop) err <= 1'b1;
      else if (stat_wr & wdata[3]) err <= 1'b0;

      if (ie & rdy & ~rdy_q) irq_q <= 1'b1;
      else if (stat_wr & wdata[7]) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_host_ctrl_chk.sv
module cfg_host_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ack,
  input logic irq,
  input logic ie,
  input logic rdy,
  input logic init,
  input logic prog,
  input logic loc_vld,
  input logic chain_vld
);
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_ack_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));
  p_rdy_needs_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (init && prog));
  p_chain_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_vld |-> !rdy);
  p_prog_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog |=> (!init && !loc_vld && !chain_vld));
  p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && rdy && !$past(rdy)) |=> irq);
endmodule

bind cfg_host_ctrl cfg_host_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .irq(irq), .ie(ie),
  .rdy(rdy), .init(init), .prog(prog), .loc_vld(loc_vld), .chain_vld(chain_vld)
);

// File: tb/tb_cfg_host_ctrl.sv
module tb_cfg_host_ctrl;
  localparam int CLK_P = 10;
  localparam int INIT  = 16;
  localparam int DIV   = 4;

  logic clk = 0, rst_n = 0, req = 0, we = 0, cfg_done = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ack, irq, loc_dat, loc_vld, chain_dat, chain_vld;

  int checks = 0, fails = 0;
  int loc_n = 0, chain_n = 0;
  logic [15:0] loc_acc = 0;
  logic [7:0]  chain_acc = 0;
  bit finished = 0;

  cfg_host_ctrl #(.INIT_DLY(INIT), .LOC_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .cfg_done(cfg_done), .irq(irq),
    .loc_dat(loc_dat), .loc_vld(loc_vld), .chain_dat(chain_dat), .chain_vld(chain_vld)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (loc_vld) begin loc_acc <= {loc_acc[14:0], loc_dat}; loc_n <= loc_n + 1; end
    if (chain_vld) begin chain_acc <= {chain_acc[6:0], chain_dat}; chain_n <= chain_n + 1; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output int n);
    @(posedge clk);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; n = 0;
    do begin @(posedge clk); #1; n++; end while (!ack && n < 1000);
    rd = rdata;
    req = 0; we = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int n);
    logic [7:0] rd;
    bus(1'b1, a, d, rd, n);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    int n;
    bus(1'b0, a, 8'h00, v, n);
  endtask

  task automatic wait_cyc(input int c);
    repeat (c) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(2'd0, v); chk(v == 8'h00, "R1 ctrl reset", v, 8'h00);
    rd_reg(2'd1, v); chk(v == 8'h00, "R1 status reset", v, 8'h00);
    rd_reg(2'd2, v); chk(v == 8'h00, "R9 data reads zero", v, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] v; int n;
    wr(2'd0, 8'h01, n);
    rd_reg(2'd1, v); chk(v[1] == 1'b0, "R2 init low early", v[1], 0);
    wr(2'd2, 8'h77, n); chk(n == 1, "R5 early ack on drop", n, 1);
    wait_cyc(INIT + 2);
    rd_reg(2'd1, v); chk(v == 8'h0B, "R2 R3 R7 init ready err", v, 8'h0B);
    wr(2'd1, 8'h08, n);
    rd_reg(2'd1, v); chk(v == 8'h03, "R7 err cleared", v, 8'h03);
    chk(loc_n == 0, "R7 dropped byte not sent", loc_n, 0);
  endtask

  task automatic t_local_early();
    logic [7:0] v; int n, n0;
    n0 = loc_n;
    wr(2'd2, 8'hA5, n); chk(n == 1, "R5 early ack", n, 1);
    wr(2'd2, 8'h3C, n); chk(n == 1, "R5 early ack second", n, 1);
    wr(2'd2, 8'hFF, n);
    rd_reg(2'd1, v); chk(v[3] == 1'b1, "R7 overrun err", v[3], 1);
    wait_cyc(2 * 8 * DIV + 10);
    chk(loc_n - n0 == 16, "R4 local bit count", loc_n - n0, 16);
    chk(loc_acc == 16'hA53C, "R4 R7 local bytes", loc_acc, 16'hA53C);
    wr(2'd1, 8'h08, n);
  endtask

  task automatic t_local_spacing();
    int n, c0, c1;
    wr(2'd2, 8'h81, n);
    while (!loc_vld) @(negedge clk);
    c0 = 0;
    @(negedge clk);
    c1 = 1;
    while (!loc_vld && c1 < 100) begin @(negedge clk); c1++; end
    chk(c1 == DIV, "R4 local strobe spacing", c1, DIV);
    c0 = c0 + 1;
    wait_cyc(8 * DIV + 4);
  endtask

  task automatic t_hold();
    int n0, n1, b0;
    b0 = loc_n;
    wr(2'd0, 8'h03, n0);
    wr(2'd2, 8'h5A, n0); chk(n0 == 2, "R6 held ack idle", n0, 2);
    wr(2'd2, 8'hC3, n1); chk(n1 >= 8, "R6 held ack waits", n1, 8);
    wait_cyc(8 * DIV + 10);
    chk(loc_n - b0 == 16, "R6 held bit count", loc_n - b0, 16);
    chk(loc_acc == 16'h5AC3, "R6 held bytes", loc_acc, 16'h5AC3);
  endtask

  task automatic t_daisy();
    logic [7:0] v; int n, l0, c0;
    l0 = loc_n; c0 = chain_n;
    wr(2'd0, 8'h05, n);
    wr(2'd2, 8'h96, n); chk(n == 1, "R5 chain early ack", n, 1);
    rd_reg(2'd1, v); chk(v[0] == 1'b0, "R3 busy while shifting", v[0], 0);
    wait_cyc(12);
    rd_reg(2'd1, v); chk(v[0] == 1'b1, "R3 ready after last bit", v[0], 1);
    chk(chain_n - c0 == 8, "R4 chain bit count", chain_n - c0, 8);
    chk(chain_acc == 8'h96, "R4 chain byte", chain_acc, 8'h96);
    chk(loc_n == l0, "R4 local silent in chain", loc_n - l0, 0);
  endtask

  task automatic t_irq();
    logic [7:0] v; int n;
    wr(2'd0, 8'h0D, n);
    rd_reg(2'd0, v); chk(v == 8'h0D, "R1 ctrl readback", v, 8'h0D);
    chk(irq == 1'b0, "R8 no irq without rise", irq, 0);
    wr(2'd2, 8'h81, n);
    wait_cyc(12);
    chk(irq == 1'b1, "R8 irq on ready rise", irq, 1);
    rd_reg(2'd1, v); chk(v[7] == 1'b1, "R8 status irq bit", v[7], 1);
    wr(2'd1, 8'h80, n);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);
    chk(chain_acc == 8'h81, "R4 chain byte two", chain_acc, 8'h81);
  endtask

  task automatic t_prog_clear();
    logic [7:0] v; int n, c0;
    wr(2'd0, 8'h05, n);
    c0 = chain_n;
    wr(2'd2, 8'hF0, n);
    wr(2'd0, 8'h04, n);
    wait_cyc(12);
    chk(chain_n - c0 < 8, "R2 prog low stops shift", chain_n - c0, 7);
    rd_reg(2'd1, v); chk(v == 8'h00, "R2 status after prog low", v, 8'h00);
    wr(2'd0, 8'h01, n);
    wait_cyc(INIT + 2);
    rd_reg(2'd1, v); chk(v == 8'h03, "R2 re-init", v, 8'h03);
  endtask

  task automatic t_hold_noinit();
    logic [7:0] v; int n;
    wr(2'd0, 8'h02, n);
    wr(2'd2, 8'h11, n); chk(n == 1, "R6 R7 held write without init acked", n, 1);
    rd_reg(2'd1, v); chk(v == 8'h08, "R7 err without init", v, 8'h08);
    wr(2'd1, 8'h08, n);
  endtask

  task automatic t_done();
    logic [7:0] v;
    cfg_done = 1;
    rd_reg(2'd1, v); chk(v[2] == 1'b1, "R10 done high", v[2], 1);
    cfg_done = 0;
    rd_reg(2'd1, v); chk(v[2] == 1'b0, "R10 done low", v[2], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_init();
    t_local_early();
    t_local_spacing();
    t_hold();
    t_daisy();
    t_irq();
    t_prog_clear();
    t_hold_noinit();
    t_done();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule